// File: doc/BRIEF.md
# Load/Store Data Formatter

This block sits between a 64-bit memory data bus and the integer register file. For a load it takes the raw doubleword returned from memory, the low three address bits, the access size, a sign-extend flag and a byte-reverse flag. From these it produces a register-ready result: one 32-bit value for byte, halfword and word loads, or a pair of 32-bit halves for a doubleword load. For a store it places the store data in the addressed byte lanes of the bus and produces the matching byte-enable mask.

The bus is big-endian. Address offset 0 is the most significant byte of the doubleword. The block has two register stages and accepts a new access on every cycle, so back-to-back accesses deliver one result per cycle. While a load sits in the first stage, a load-to-use flag is raised. This lets the issue logic hold back a dependent instruction for one cycle. An access that is not aligned to its own size is flagged as an error and causes no write.

Top module: `ldst_formatter`

## Requirements
- R1: During and after reset, before any access, `out_valid`, `out_wr_en`, `out_pair`, `out_align_err`, `ld_use`, `out_be`, `out_hi` and `out_lo` are all zero.
- R2: Byte load (`in_size`=0): the byte at offset `a` is `in_rdata[63-8a -: 8]`. It goes to `out_lo`, zero-extended when `in_sext`=0 and sign-extended from bit 7 when `in_sext`=1. `out_hi` is zero.
- R3: Halfword load (`in_size`=1): bytes `a` and `a+1` form the value, with byte `a` most significant. It goes to `out_lo`, zero-extended or sign-extended from bit 15 according to `in_sext`. `out_hi` is zero.
- R4: Word load (`in_size`=2): bytes `a`..`a+3` form `out_lo`, with byte `a` most significant. `in_sext` has no effect and `out_hi` is zero.
- R5: Doubleword load (`in_size`=3): `out_hi` holds bytes 0..3 and `out_lo` holds bytes 4..7. `out_pair` is 1.
- R6: With `in_brev`=1 the bytes of the accessed field are taken in reverse order. This happens before extension, so the sign comes from the byte that lands most significant.
- R7: An access with `in_addr` not a multiple of its size (1, 2, 4 or 8 bytes) raises `out_align_err`. It also forces `out_wr_en`=0 and `out_be`=0.
- R8: Store (`in_store`=1): the low 1/2/4/8 bytes of `in_wdata` are replicated into every lane group of that size in `out_st_data`. `out_be[k]` is 1 exactly for the accessed lanes `a`..`a+n-1`, where lane k is `out_st_data[63-8k -: 8]`. `out_wr_en` is 0.
- R9: A store with `in_brev`=1 reverses the byte order of the store field before replication.
- R10: Each access accepted with `in_valid` appears on the outputs with `out_valid` exactly two clock edges later. Accesses may be issued on every cycle.
- R11: `ld_use` is 1 exactly in the cycle after a load was accepted, that is, one cycle before that load's result appears. It is 0 after a store or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Access present this cycle |
| in_store | input | 1 | 1 = store, 0 = load |
| in_addr | input | 3 | Byte offset within the doubleword |
| in_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| in_sext | input | 1 | Sign-extend byte and halfword loads |
| in_brev | input | 1 | Reverse byte order of the accessed field |
| in_rdata | input | 64 | Raw doubleword read from memory |
| in_wdata | input | 64 | Store data, right-justified |
| ld_use | output | 1 | A load is one cycle from its result |
| out_valid | output | 1 | Result of an access present |
| out_wr_en | output | 1 | Register write for an aligned load |
| out_pair | output | 1 | Write goes to a register pair |
| out_hi | output | 32 | Upper half of a doubleword load |
| out_lo | output | 32 | Load result, or lower half of a doubleword |
| out_align_err | output | 1 | Misaligned access |
| out_st_data | output | 64 | Store data placed on the bus lanes |
| out_be | output | 8 | Byte enables, bit k for offset k |

## Verification
In a back-to-back stream, one access's result leaves the second stage in the same cycle that the next load's `ld_use` flag is raised by the first stage. The bench issues a load, store or idle slot on every cycle over all offsets, sizes and flag settings. At each falling edge it judges the output of the access issued two slots earlier and the `ld_use` value of the access issued one slot earlier, each against values computed byte by byte from the requirements. Misaligned accesses are interleaved with aligned ones, so an error result and a valid write also appear on neighbouring cycles.

// File: rtl/ldst_formatter.sv
module ldst_formatter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_store,
  input  logic [2:0]  in_addr,
  input  logic [1:0]  in_size,
  input  logic        in_sext,
  input  logic        in_brev,
  input  logic [63:0] in_rdata,
  input  logic [63:0] in_wdata,
  output logic        ld_use,
  output logic        out_valid,
  output logic        out_wr_en,
  output logic        out_pair,
  output logic [31:0] out_hi,
  output logic [31:0] out_lo,
  output logic        out_align_err,
  output logic [63:0] out_st_data,
  output logic [7:0]  out_be
);

  logic        s1_v, s1_st, s1_sx, s1_rv;
  logic [2:0]  s1_a;
  logic [1:0]  s1_sz;
  logic [63:0] s1_rd, s1_wd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_st <= 1'b0; s1_sx <= 1'b0; s1_rv <= 1'b0;
      s1_a <= '0; s1_sz <= '0; s1_rd <= '0; s1_wd <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_st <= in_store; s1_sx <= in_sext; s1_rv <= in_brev;
        s1_a <= in_addr; s1_sz <= in_size; s1_rd <= in_rdata; s1_wd <= in_wdata;
      end
    end
  end

  assign ld_use = s1_v & ~s1_st;

  function automatic logic [63:0] rev8(input logic [63:0] d);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = d[63-8*i -: 8];
    return r;
  endfunction

  logic [3:0]  nb;
  logic [2:0]  amask;
  logic [5:0]  rsh;
  logic        mis;
  logic [63:0] ld_raw, ld_fmt, st_raw, st_fmt, st_rep;
  logic [31:0] lo_n, hi_n;
  logic [8:0]  bm;
  logic [7:0]  be_n;

  assign nb     = 4'd1 << s1_sz;
  assign amask  = nb[2:0] - 3'd1;
  assign rsh    = {~amask, 3'b000};
  assign mis    = |(s1_a & amask);
  assign ld_raw = (s1_rd << {s1_a, 3'b000}) >> rsh;
  assign ld_fmt = s1_rv ? (rev8(ld_raw) >> rsh) : ld_raw;
  assign st_raw = s1_wd & ({64{1'b1}} >> rsh);
  assign st_fmt = s1_rv ? (rev8(st_raw) >> rsh) : st_raw;
  assign bm     = (9'd1 << nb) - 9'd1;
  assign be_n   = bm[7:0] << s1_a;
  assign hi_n   = (s1_sz == 2'd3) ? ld_fmt[63:32] : 32'd0;

  always_comb begin
    case (s1_sz)
      2'd0:    lo_n = {{24{s1_sx & ld_fmt[7]}}, ld_fmt[7:0]};
      2'd1:    lo_n = {{16{s1_sx & ld_fmt[15]}}, ld_fmt[15:0]};
      default: lo_n = ld_fmt[31:0];
    endcase
    case (s1_sz)
      2'd0:    st_rep = {8{st_fmt[7:0]}};
      2'd1:    st_rep = {4{st_fmt[15:0]}};
      2'd2:    st_rep = {2{st_fmt[31:0]}};
      default: st_rep = st_fmt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_wr_en <= 1'b0; out_pair <= 1'b0;
      out_hi <= '0; out_lo <= '0; out_align_err <= 1'b0;
      out_st_data <= '0; out_be <= '0;
    end else begin
      out_valid     <= s1_v;
      out_wr_en     <= s1_v & ~s1_st & ~mis;
      out_pair      <= s1_v & ~s1_st & ~mis & (s1_sz == 2'd3);
      out_hi        <= hi_n;
      out_lo        <= lo_n;
      out_align_err <= s1_v & mis;
      out_st_data   <= st_rep;
      out_be        <= (s1_v & s1_st & ~mis) ? be_n : 8'd0;
    end
  end

  p_err_blocks_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_align_err |-> (!out_wr_en && out_be == 8'd0));
  p_two_stage_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);
  p_ld_use_then_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_use |=> (out_valid && out_be == 8'd0));
  p_pair_is_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_pair |-> out_wr_en);
  p_be_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_be != 8'd0) |-> ($countones(out_be) == 1 || $countones(out_be) == 2 ||
                          $countones(out_be) == 4 || $countones(out_be) == 8));
  p_store_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_be != 8'd0) |-> !out_wr_en);

endmodule

// File: tb/ldst_formatter_tb.sv
module ldst_formatter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXS = 640;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_store = 0, in_sext = 0, in_brev = 0;
  logic [2:0] in_addr = 0;
  logic [1:0] in_size = 0;
  logic [63:0] in_rdata = 0, in_wdata = 0;
  logic ld_use, out_valid, out_wr_en, out_pair, out_align_err;
  logic [31:0] out_hi, out_lo;
  logic [63:0] out_st_data;
  logic [7:0] out_be;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldst_formatter dut_i (.clk, .rst_n, .in_valid, .in_store, .in_addr, .in_size,
    .in_sext, .in_brev, .in_rdata, .in_wdata, .ld_use, .out_valid, .out_wr_en,
    .out_pair, .out_hi, .out_lo, .out_align_err, .out_st_data, .out_be);

  int total = 0, bad = 0;
  bit done = 0;

  logic        sv[MAXS], sst[MAXS], ssx[MAXS], srv[MAXS];
  logic [2:0]  sa[MAXS];
  logic [1:0]  ssz[MAXS];
  logic [63:0] srd[MAXS], swd[MAXS];
  int ns;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_slot(input int s);
    int n, a;
    bit al;
    logic [63:0] v, f;
    logic [7:0] b, ebe;
    logic [31:0] elo, ehi;
    logic [63:0] ed;
    if (!sv[s]) begin
      chk("R10 idle valid", 64'(out_valid), 0);
      return;
    end
    chk("R10 valid", 64'(out_valid), 1);
    n = 1 << ssz[s]; a = sa[s];
    al = (a % n) == 0;
    chk("R7 align_err", 64'(out_align_err), 64'(!al));
    if (!al) begin
      chk("R7 no wr_en", 64'(out_wr_en), 0);
      chk("R7 no be", 64'(out_be), 0);
      return;
    end
    if (!sst[s]) begin
      v = 0;
      for (int j = 0; j < n; j++) begin
        int k;
        k = srv[s] ? a + n - 1 - j : a + j;
        b = srd[s][63-8*k -: 8];
        v = (v << 8) | 64'(b);
      end
      ehi = 0;
      case (n)
        1: elo = ssx[s] ? {{24{v[7]}}, v[7:0]} : {24'd0, v[7:0]};
        2: elo = ssx[s] ? {{16{v[15]}}, v[15:0]} : {16'd0, v[15:0]};
        4: elo = v[31:0];
        default: begin elo = v[31:0]; ehi = v[63:32]; end
      endcase
      chk(srv[s] ? "R6 load lo" : (n == 1 ? "R2 byte lo" : n == 2 ? "R3 half lo" : n == 4 ? "R4 word lo" : "R5 dword lo"),
          64'(out_lo), 64'(elo));
      chk("R5 hi", 64'(out_hi), 64'(ehi));
      chk("R5 pair", 64'(out_pair), 64'(n == 8));
      chk("R2 wr_en", 64'(out_wr_en), 1);
      chk("R8 load be", 64'(out_be), 0);
    end else begin
      f = 0;
      for (int j = 0; j < n; j++) begin
        b = srv[s] ? swd[s][8*j +: 8] : swd[s][8*(n-1-j) +: 8];
        f = (f << 8) | 64'(b);
      end
      ed = 0; ebe = 0;
      for (int k = 0; k < 8; k++) begin
        ed[63-8*k -: 8] = f[8*(n-1-(k % n)) +: 8];
        ebe[k] = (k >= a) && (k < a + n);
      end
      chk(srv[s] ? "R9 store data" : "R8 store data", out_st_data, ed);
      chk("R8 be", 64'(out_be), 64'(ebe));
      chk("R8 store wr_en", 64'(out_wr_en), 0);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s, k;
    s = 0; k = 0;
    for (int rep = 0; rep < 2; rep++)
      for (int st = 0; st < 2; st++)
        for (int sz = 0; sz < 4; sz++)
          for (int a = 0; a < 8; a++)
            for (int fl = 0; fl < 4; fl++) begin
              if (s % 7 == 6) begin sv[s] = 0; sst[s] = 0; s++; end
              sv[s] = 1; sst[s] = st[0]; sa[s] = a[2:0]; ssz[s] = sz[1:0];
              ssx[s] = fl[0]; srv[s] = fl[1];
              srd[s] = {32'(k) * 32'h9E3779B9, ~(32'(k) * 32'h85EBCA6B)} ^ (rep ? 64'h8080_8080_8080_8080 : 64'h0);
              swd[s] = {32'(k) * 32'hC2B2AE35, 32'(k) * 32'h27D4EB2F + 32'h80};
              s++; k++;
            end
    ns = s;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 valid", 64'(out_valid), 0);
    chk("R1 ld_use", 64'(ld_use), 0);
    chk("R1 outs", {out_hi, out_lo}, 0);
    chk("R1 flags", {53'd0, out_wr_en, out_pair, out_align_err, out_be}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset valid", 64'(out_valid), 0);

    for (int t = 0; t < ns + 2; t++) begin
      @(negedge clk);
      if (t >= 2) check_slot(t - 2);
      if (t >= 1) chk("R11 ld_use", 64'(ld_use), 64'(sv[t-1] && !sst[t-1]));
      if (t < ns) begin
        in_valid = sv[t]; in_store = sst[t]; in_addr = sa[t]; in_size = ssz[t];
        in_sext = ssx[t]; in_brev = srv[t]; in_rdata = srd[t]; in_wdata = swd[t];
      end else in_valid = 0;
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule